// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Processor Level Gate

This block chooses one interrupt to hand to the processor from everything that is pending in a cycle. There are two kinds of source. Peripheral sources each carry a 3-bit software priority level and are masked by the processor's current interrupt priority level and by the global interrupt enable flag. Special sources are reset, non-maskable, debug, watchdog, single step and address match. They ignore the enable flag and always take precedence over peripheral requests.

Selection has two tiers. The effective level is compared first, and special sources rank above every peripheral level. When levels are equal, a fixed hardware rank decides. Each source has a unique index, and a lower index means a higher hardware rank. The winner is registered together with a one-cycle accept pulse, so the processor sees a stable source index and level. While the processor signals that an earlier accept is still being handled, no new accept is issued.

Source index encoding, with N peripherals: 0 reset, 1 non-maskable, 2 debug, 3 watchdog, 4..3+N peripheral 0..N-1, 4+N single step, 5+N address match.

Top module: `irq_prio_arb`

## Requirements
- R1: Any pending special source wins over every pending peripheral, whatever the peripheral levels, the processor level or the enable flag.
- R2: Among special sources the winner follows the fixed rank reset, non-maskable, debug, watchdog, single step, address match, reported as indices 0, 1, 2, 3, 4+N and 5+N.
- R3: Among eligible peripherals, the one with the highest 3-bit level wins.
- R4: Among eligible peripherals with equal level, the lowest peripheral number wins, reported as index 4+i.
- R5: A peripheral is eligible only if its level is strictly greater than the 3-bit processor level.
- R6: With the enable flag at 0 no peripheral is accepted, while special sources are still accepted.
- R7: A peripheral at level 0 is never accepted.
- R8: The accept output is high for exactly one cycle and is never high in two consecutive cycles. A request that is still pending causes a new accept after one idle cycle.
- R9: No accept is issued in the cycle after a cycle in which the ack-pending input was high.
- R10: The source index and level outputs are loaded only on the clock edge that raises accept, and hold their values otherwise. A special source reports level 8 and a peripheral reports its own level.
- R11: After reset, accept, source index and level are all 0. Reset takes effect asynchronously and is released on the clock two cycles after the reset input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_req | input | 4 | Special requests: bit0 reset, bit1 non-maskable, bit2 debug, bit3 watchdog |
| lo_req | input | 2 | Special requests: bit0 single step, bit1 address match |
| per_req | input | NPERIPH | Peripheral request lines |
| per_lvl | input | 3*NPERIPH | Peripheral levels, peripheral i in bits 3i+2..3i |
| cpu_ipl | input | 3 | Processor interrupt priority level |
| int_en | input | 1 | Global interrupt enable flag |
| ack_pend | input | 1 | Processor still handling an earlier accept |
| acc | output | 1 | One-cycle accept pulse |
| acc_src | output | clog2(NPERIPH+6) | Index of the accepted source |
| acc_lvl | output | 4 | Effective level of the accepted source (8 for special) |

## Verification
The bench builds the block with five peripherals. That gives eleven sources and a selection tree padded to sixteen leaves, so the empty leaves and an index width that is not exactly filled are both exercised. Five peripherals are enough to create three-way level ties and to place peripherals on both sides of the processor level. A reference model in the bench is compared every cycle, through directed cases for each rule and a long random run that mixes ack-pending, enable and processor level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int HI_N   = 4;             // reset, nmi, debug, watchdog
  localparam int LO_N   = 2;             // single step, address match
  localparam int LVL_W  = 3;             // software level width
  localparam int EFF_W  = LVL_W + 1;     // effective level width
  localparam logic [EFF_W-1:0] SPECIAL_LVL = EFF_W'(1 << LVL_W);
endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify
  import irq_arb_pkg::*;
#(
  parameter int NPERIPH = 8,
  localparam int NSRC   = HI_N + NPERIPH + LO_N
) (
  input  logic [HI_N-1:0]               hi_req,
  input  logic [LO_N-1:0]               lo_req,
  input  logic [NPERIPH-1:0]            per_req,
  input  logic [NPERIPH*LVL_W-1:0]      per_lvl,
  input  logic [LVL_W-1:0]              cpu_ipl,
  input  logic                          int_en,
  output logic [NSRC-1:0]               src_vld,
  output logic [NSRC-1:0][EFF_W-1:0]    src_lvl
);
  genvar g;
  generate
    for (g = 0; g < HI_N; g++) begin : g_hi
      assign src_vld[g] = hi_req[g];
      assign src_lvl[g] = SPECIAL_LVL;
    end
    for (g = 0; g < NPERIPH; g++) begin : g_per
      logic [LVL_W-1:0] lv;
      assign lv = per_lvl[g*LVL_W +: LVL_W];
      assign src_vld[HI_N+g] = per_req[g] & int_en & (lv > cpu_ipl);
      assign src_lvl[HI_N+g] = {1'b0, lv};
    end
    for (g = 0; g < LO_N; g++) begin : g_lo
      assign src_vld[HI_N+NPERIPH+g] = lo_req[g];
      assign src_lvl[HI_N+NPERIPH+g] = SPECIAL_LVL;
    end
  endgenerate
endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree
  import irq_arb_pkg::*;
#(
  parameter int NSRC  = 14,
  localparam int IW    = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DEPTH = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int NLEAF = 1 << DEPTH
) (
  input  logic [NSRC-1:0]            src_vld,
  input  logic [NSRC-1:0][EFF_W-1:0] src_lvl,
  output logic                       win_vld,
  output logic [EFF_W-1:0]           win_lvl,
  output logic [IW-1:0]              win_idx
);
  // node k has children 2k and 2k+1; the root is node 1
  logic             nv [1:2*NLEAF-1];
  logic [EFF_W-1:0] nl [1:2*NLEAF-1];
  logic [IW-1:0]    ni [1:2*NLEAF-1];

  genvar j;
  generate
    for (j = 0; j < NLEAF; j++) begin : g_leaf
      if (j < NSRC) begin : g_real
        assign nv[NLEAF+j] = src_vld[j];
        assign nl[NLEAF+j] = src_lvl[j];
        assign ni[NLEAF+j] = IW'(j);
      end else begin : g_pad
        assign nv[NLEAF+j] = 1'b0;
        assign nl[NLEAF+j] = '0;
        assign ni[NLEAF+j] = '0;
      end
    end
    for (j = 1; j < NLEAF; j++) begin : g_node
      logic take_left;
      // left child holds lower indices: it wins ties
      assign take_left = nv[2*j] & (~nv[2*j+1] | (nl[2*j] >= nl[2*j+1]));
      assign nv[j] = nv[2*j] | nv[2*j+1];
      assign nl[j] = take_left ? nl[2*j] : nl[2*j+1];
      assign ni[j] = take_left ? ni[2*j] : ni[2*j+1];
    end
  endgenerate

  assign win_vld = nv[1];
  assign win_lvl = nl[1];
  assign win_idx = ni[1];
endmodule

// File: rtl/irq_accept_reg.sv
module irq_accept_reg
  import irq_arb_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_vld,
  input  logic [EFF_W-1:0] win_lvl,
  input  logic [IW-1:0]    win_idx,
  input  logic             ack_pend,
  output logic             acc,
  output logic [IW-1:0]    acc_src,
  output logic [EFF_W-1:0] acc_lvl
);
  logic [1:0]       rsync_q;
  logic             rst_sn;
  logic             acc_q, acc_d;
  logic             ld_en;
  logic [IW-1:0]    src_q, src_d;
  logic [EFF_W-1:0] lvl_q, lvl_d;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  always_comb begin
    acc_d = win_vld & ~ack_pend & ~acc_q;
    ld_en = acc_d;
    src_d = ld_en ? win_idx : src_q;
    lvl_d = ld_en ? win_lvl : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q <= 1'b0;
      src_q <= '0;
      lvl_q <= '0;
    end else begin
      acc_q <= acc_d;
      src_q <= src_d;
      lvl_q <= lvl_d;
    end
  end

  assign acc     = acc_q;
  assign acc_src = src_q;
  assign acc_lvl = lvl_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    acc |=> !acc);                                          // R8
  AST_ACKPEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sn)
    ack_pend |=> !acc);                                     // R9
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !acc |-> ($stable(acc_src) && $stable(acc_lvl)));       // R10
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NPERIPH = 8,
  localparam int NSRC   = HI_N + NPERIPH + LO_N,
  localparam int IW     = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HI_N-1:0]          hi_req,
  input  logic [LO_N-1:0]          lo_req,
  input  logic [NPERIPH-1:0]       per_req,
  input  logic [NPERIPH*LVL_W-1:0] per_lvl,
  input  logic [LVL_W-1:0]         cpu_ipl,
  input  logic                     int_en,
  input  logic                     ack_pend,
  output logic                     acc,
  output logic [IW-1:0]            acc_src,
  output logic [EFF_W-1:0]         acc_lvl
);
  logic [NSRC-1:0]            src_vld;
  logic [NSRC-1:0][EFF_W-1:0] src_lvl;
  logic                       win_vld;
  logic [EFF_W-1:0]           win_lvl;
  logic [IW-1:0]              win_idx;
  logic                       win_is_per;

  irq_src_qualify #(.NPERIPH(NPERIPH)) u_qual (
    .hi_req(hi_req), .lo_req(lo_req), .per_req(per_req), .per_lvl(per_lvl),
    .cpu_ipl(cpu_ipl), .int_en(int_en), .src_vld(src_vld), .src_lvl(src_lvl)
  );

  irq_sel_tree #(.NSRC(NSRC)) u_tree (
    .src_vld(src_vld), .src_lvl(src_lvl),
    .win_vld(win_vld), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  irq_accept_reg #(.IW(IW)) u_acc (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_lvl(win_lvl),
    .win_idx(win_idx), .ack_pend(ack_pend),
    .acc(acc), .acc_src(acc_src), .acc_lvl(acc_lvl)
  );

  assign win_is_per = (win_idx >= IW'(HI_N)) && (win_idx < IW'(HI_N + NPERIPH));

  AST_PER_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && win_is_per) |-> (int_en && (win_lvl[LVL_W-1:0] > cpu_ipl))); // R5
  AST_SPECIAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hi_req) || (|lo_req)) |-> (win_vld && !win_is_per));                 // R1
endmodule

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 5;
  localparam int NS   = 4 + NP + 2;
  localparam int IW   = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0]      hi_req;
  logic [1:0]      lo_req;
  logic [NP-1:0]   per_req;
  logic [NP*3-1:0] per_lvl;
  logic [2:0]      cpu_ipl;
  logic            int_en;
  logic            ack_pend;
  logic            acc;
  logic [IW-1:0]   acc_src;
  logic [3:0]      acc_lvl;

  int checks = 0;
  int errors = 0;
  int e_acc = 0, e_src = 0, e_lvl = 0;

  irq_prio_arb #(.NPERIPH(NP)) uut (
    .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .lo_req(lo_req),
    .per_req(per_req), .per_lvl(per_lvl), .cpu_ipl(cpu_ipl), .int_en(int_en),
    .ack_pend(ack_pend), .acc(acc), .acc_src(acc_src), .acc_lvl(acc_lvl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // source order by hardware rank: 0..3 high specials, 4..4+NP-1 peripherals, then sstep, amatch
  function automatic void model_winner(output int idx, output int lvl);
    int best = -1, bl = -1;
    for (int s = 0; s < NS; s++) begin
      bit v; int l;
      if (s < 4) begin v = hi_req[s]; l = 8; end
      else if (s < 4 + NP) begin
        l = int'(per_lvl[(s-4)*3 +: 3]);
        v = per_req[s-4] && int_en && (l > int'(cpu_ipl));
      end else begin v = lo_req[s-4-NP]; l = 8; end
      if (v && l > bl) begin best = s; bl = l; end
    end
    idx = best; lvl = bl;
  endfunction

  task automatic check(string tag);
    checks++;
    if (acc !== e_acc[0] || acc_src !== IW'(e_src) || acc_lvl !== 4'(e_lvl)) begin
      errors++;
      $display("FAIL %s: actual acc=%0b src=%0d lvl=%0d expected acc=%0b src=%0d lvl=%0d",
               tag, acc, acc_src, acc_lvl, e_acc, e_src, e_lvl);
    end
  endtask

  // inputs are set by the caller at a negedge; model advances with the edge
  task automatic tick(string tag);
    int wi, wl, na;
    model_winner(wi, wl);
    na = (wi >= 0 && !ack_pend && e_acc == 0) ? 1 : 0;
    @(posedge clk);
    e_acc = na;
    if (na == 1) begin e_src = wi; e_lvl = wl; end
    @(negedge clk);
    check(tag);
  endtask

  task automatic clear_in();
    hi_req = '0; lo_req = '0; per_req = '0; per_lvl = '0;
    cpu_ipl = '0; int_en = 1'b0; ack_pend = 1'b0;
  endtask

  task automatic set_lvl(int p, int l);
    per_lvl[p*3 +: 3] = 3'(l);
  endtask

  // let any pulse finish and ensure the next accept can fire
  task automatic idle(string tag);
    clear_in(); tick(tag); tick(tag);
  endtask

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick("R11");
    check("R11"); // reset state: all zero

    // R2: special rank, one at a time and in combinations
    hi_req = 4'b1111; lo_req = 2'b11; tick("R2");
    idle("R2");
    hi_req = 4'b1110; lo_req = 2'b11; tick("R2");
    idle("R2");
    hi_req = 4'b1000; lo_req = 2'b11; tick("R2");
    idle("R2");
    lo_req = 2'b10; tick("R2");
    idle("R2");

    // R1/R6: special beats level-7 peripheral, enable off or on
    per_req = '1; for (int p = 0; p < NP; p++) set_lvl(p, 7);
    int_en = 1'b1; lo_req = 2'b01; tick("R1");
    idle("R1");
    per_req = '1; int_en = 1'b0; hi_req = 4'b0100; tick("R6");
    idle("R6");
    per_req = '1; for (int p = 0; p < NP; p++) set_lvl(p, 7);
    int_en = 1'b0; tick("R6"); tick("R6");
    idle("R6");

    // R3: highest level wins
    int_en = 1'b1; per_req = 5'b11111;
    set_lvl(0, 2); set_lvl(1, 5); set_lvl(2, 3); set_lvl(3, 6); set_lvl(4, 1);
    tick("R3");
    idle("R3");

    // R4: three-way tie at level 4, lowest number wins
    int_en = 1'b1; per_req = 5'b11010;
    set_lvl(1, 4); set_lvl(3, 4); set_lvl(4, 4);
    tick("R4");
    idle("R4");

    // R5: level equal to IPL is rejected, one above accepted
    int_en = 1'b1; cpu_ipl = 3'd4; per_req = 5'b00001; set_lvl(0, 4);
    tick("R5"); tick("R5");
    set_lvl(0, 5); tick("R5");
    idle("R5");

    // R7: level 0 with IPL 0 never accepted
    int_en = 1'b1; cpu_ipl = 3'd0; per_req = '1; tick("R7"); tick("R7");
    idle("R7");

    // R8: steady request gives alternate pulses
    int_en = 1'b1; per_req = 5'b00100; set_lvl(2, 3);
    repeat (6) tick("R8");
    idle("R8");

    // R9/R10: ack pending blocks; outputs hold
    hi_req = 4'b0010; ack_pend = 1'b1;
    repeat (4) tick("R9");
    ack_pend = 1'b0; tick("R10"); tick("R10");
    idle("R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      hi_req  = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
      lo_req  = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b0;
      per_req = NP'($urandom);
      per_lvl = (NP*3)'($urandom);
      cpu_ipl = 3'($urandom);
      int_en  = ($urandom_range(0, 3) != 0);
      ack_pend = ($urandom_range(0, 3) == 0);
      tick("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule